// File: doc/BRIEF.md
# Character Buffer Bus Port

This block is the bus-facing front end of a character display controller. A pipelined bus master reads and writes 16-bit words at 11-bit word addresses. The lower part of the address space is a character buffer of 1280 words, which holds 2560 character bytes. One address above that buffer is a single on/off control register for video generation. Every other address is left unused.

Characters are stored two per word. The low byte of a word is the character at the earlier screen position. Any byte that is not a 7-bit code is replaced on its way into the buffer. Both regions can be read back over the bus. The display side gets its own synchronous read port into the buffer and a level that says whether output is switched on.

Every access the block accepts is acknowledged exactly one clock later. Back-to-back strobes therefore flow at one access per cycle. The block stalls the bus only while reset is held.

Top module: `txtbuf_bus_port`

## Requirements
- R1: While `rst` is high, `stallOut` is 1 and `ackOut` is 0. After reset, `dispEnable` is 0 and a read of the control register returns 0x0000.
- R2: Outside reset `stallOut` is 0. A strobe sampled with `stallOut` low is accepted, and `ackOut` is 1 in exactly the next cycle. This holds for strobes in consecutive cycles too. `ackOut` is 0 in a cycle that does not follow an accepted strobe.
- R3: A word written to an address in 0x000..0x4FF reads back over the bus, after sanitising, on the acknowledge cycle of a later read to that address. `datOut` is valid only while `ackOut` is 1.
- R4: On a buffer write, each of the two bytes is checked on its own. A byte from 0x00 to 0x7F is stored unchanged. A byte from 0x80 to 0xFF is stored as 0x3F.
- R5: Writing a non-zero word to address 0x500 makes `dispEnable` 1 from the next cycle. Writing 0x0000 there makes it 0. A read of 0x500 returns 0x0001 while it is 1 and 0x0000 while it is 0. Nothing else changes `dispEnable`.
- R6: `dispData` presents the stored word at `dispAddr` one cycle after `dispAddr` is applied. Bits 7:0 hold character 2n and bits 15:8 hold character 2n+1 of word n.
- R7: Accesses to addresses above 0x500 are still acknowledged. Writes there change neither the buffer nor `dispEnable`, and reads there return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stbIn | input | 1 | Access strobe |
| weIn | input | 1 | 1 for write, 0 for read |
| adrIn | input | 11 | Word address |
| datIn | input | 16 | Write data |
| datOut | output | 16 | Read data, valid while ackOut is 1 |
| ackOut | output | 1 | Acknowledge, one cycle after acceptance |
| stallOut | output | 1 | Stall, high only in reset |
| dispAddr | input | 11 | Display-side word index |
| dispData | output | 16 | Stored word at dispAddr, one cycle later |
| dispEnable | output | 1 | Video output on |

## Verification
A sweep writes all 256 byte values, with the two bytes of each word on opposite sides of the 0x80 boundary. This separates per-byte sanitising from whole-word sanitising and shows which byte lanes are swapped. A full-buffer write with an arithmetic pattern is followed by one unbroken run of back-to-back reads and by a display-port scan of every word. Together these separate pipelined acknowledge timing, address aliasing and the byte order of the display port. Control-register writes of one-bit, high-bit and zero values, plus writes and reads above 0x500, show that only a non-zero word to exactly 0x500 switches output on and that the unused space has no effect.

// File: rtl/txtbuf_pkg.sv
package txtbuf_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic memWe;   // write the character buffer this cycle
    logic regWe;   // write the on/off register this cycle
    logic regVal;  // value for the on/off register
    logic rdText;  // registered: acknowledged read hits buffer
    logic rdReg;   // registered: acknowledged read hits register
  } ctrl_t;

  function automatic logic [7:0] cleanByte(input logic [7:0] b, input logic [7:0] subst);
    return b[7] ? subst : b;
  endfunction

endpackage

// File: rtl/txtbuf_ctrl.sv
module txtbuf_ctrl
  import txtbuf_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 16,
  parameter int TEXT_WORDS  = 1280,
  parameter int ENABLE_ADDR = 'h500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stbIn,
  input  logic              weIn,
  input  logic [ADDR_W-1:0] adrIn,
  input  logic [DATA_W-1:0] datIn,
  output logic              ackOut,
  output logic              stallOut,
  output ctrl_t             ctl
);
  localparam logic [ADDR_W-1:0] TEXT_END = ADDR_W'(TEXT_WORDS);
  localparam logic [ADDR_W-1:0] REG_ADR  = ADDR_W'(ENABLE_ADDR);

  logic accept;
  logic inText;
  logic inReg;
  logic ackQ;
  logic rdTextQ;
  logic rdRegQ;

  assign stallOut = rst;
  assign accept   = stbIn && !stallOut;
  assign inText   = adrIn < TEXT_END;
  assign inReg    = adrIn == REG_ADR;

  always_ff @(posedge clk) begin
    if (rst) begin
      ackQ    <= 1'b0;
      rdTextQ <= 1'b0;
      rdRegQ  <= 1'b0;
    end else begin
      ackQ    <= accept;
      rdTextQ <= accept && !weIn && inText;
      rdRegQ  <= accept && !weIn && inReg;
    end
  end

  assign ackOut     = ackQ;
  assign ctl.memWe  = accept && weIn && inText;
  assign ctl.regWe  = accept && weIn && inReg;
  assign ctl.regVal = |datIn;
  assign ctl.rdText = rdTextQ;
  assign ctl.rdReg  = rdRegQ;

endmodule

// File: rtl/txtbuf_datapath.sv
module txtbuf_datapath
  import txtbuf_pkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter int          TEXT_WORDS = 1280,
  parameter logic [7:0]  SUBST      = 8'h3F
) (
  input  logic                          clk,
  input  logic                          rst,
  input  ctrl_t                         ctl,
  input  logic [$clog2(TEXT_WORDS)-1:0] busIdx,
  input  logic [DATA_W-1:0]             datIn,
  input  logic [$clog2(TEXT_WORDS)-1:0] dispAddr,
  output logic [DATA_W-1:0]             datOut,
  output logic [DATA_W-1:0]             dispData,
  output logic                          dispEnable
);
  localparam int BYTES = DATA_W / 8;

  logic [DATA_W-1:0] mem [TEXT_WORDS];
  logic [DATA_W-1:0] cleanWord;
  logic [DATA_W-1:0] busWord;
  logic              enableQ;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign cleanWord[g*8 +: 8] = cleanByte(datIn[g*8 +: 8], SUBST);
  end

  always_ff @(posedge clk) begin
    if (ctl.memWe) mem[busIdx] <= cleanWord;
    busWord  <= mem[busIdx];
    dispData <= mem[dispAddr];
  end

  always_ff @(posedge clk) begin
    if (rst)            enableQ <= 1'b0;
    else if (ctl.regWe) enableQ <= ctl.regVal;
  end

  always_comb begin
    datOut = '0;
    if (ctl.rdText)     datOut = busWord;
    else if (ctl.rdReg) datOut = DATA_W'(enableQ);
  end

  assign dispEnable = enableQ;

endmodule

// File: rtl/txtbuf_bus_port.sv
module txtbuf_bus_port
  import txtbuf_pkg::*;
#(
  parameter int          ADDR_W      = 11,
  parameter int          DATA_W      = 16,
  parameter int          TEXT_WORDS  = 1280,
  parameter int          ENABLE_ADDR = 'h500,
  parameter logic [7:0]  SUBST       = 8'h3F,
  localparam int         IDX_W       = $clog2(TEXT_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stbIn,
  input  logic              weIn,
  input  logic [ADDR_W-1:0] adrIn,
  input  logic [DATA_W-1:0] datIn,
  output logic [DATA_W-1:0] datOut,
  output logic              ackOut,
  output logic              stallOut,
  input  logic [IDX_W-1:0]  dispAddr,
  output logic [DATA_W-1:0] dispData,
  output logic              dispEnable
);
  ctrl_t ctl;

  txtbuf_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .TEXT_WORDS(TEXT_WORDS), .ENABLE_ADDR(ENABLE_ADDR)
  ) u_ctrl (
    .clk(clk), .rst(rst), .stbIn(stbIn), .weIn(weIn),
    .adrIn(adrIn), .datIn(datIn),
    .ackOut(ackOut), .stallOut(stallOut), .ctl(ctl)
  );

  txtbuf_datapath #(
    .DATA_W(DATA_W), .TEXT_WORDS(TEXT_WORDS), .SUBST(SUBST)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .busIdx(adrIn[IDX_W-1:0]), .datIn(datIn),
    .dispAddr(dispAddr), .datOut(datOut),
    .dispData(dispData), .dispEnable(dispEnable)
  );

endmodule

// File: rtl/txtbuf_bus_port_checker.sv
module txtbuf_bus_port_checker #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 16,
  parameter int TEXT_WORDS  = 1280,
  parameter int ENABLE_ADDR = 'h500
) (
  input logic              clk,
  input logic              rst,
  input logic              stbIn,
  input logic              weIn,
  input logic [ADDR_W-1:0] adrIn,
  input logic [DATA_W-1:0] datIn,
  input logic [DATA_W-1:0] datOut,
  input logic              ackOut,
  input logic              stallOut,
  input logic              dispEnable
);
  logic acc;
  logic regWr;
  assign acc   = stbIn && !stallOut;
  assign regWr = acc && weIn && adrIn == ADDR_W'(ENABLE_ADDR);

  a_r2_ack_follows: assert property (@(posedge clk) disable iff (rst) acc |=> ackOut);
  a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (rst) !acc |=> !ackOut);
  a_r5_enable_on: assert property (@(posedge clk) disable iff (rst) (regWr && datIn != '0) |=> dispEnable);
  a_r5_enable_off: assert property (@(posedge clk) disable iff (rst) (regWr && datIn == '0) |=> !dispEnable);
  a_r5_enable_hold: assert property (@(posedge clk) disable iff (rst) !regWr |=> $stable(dispEnable));
  a_r4_clean_readback: assert property (@(posedge clk) disable iff (rst)
    (acc && !weIn && adrIn < ADDR_W'(TEXT_WORDS)) |=> (datOut[7] == 1'b0 && datOut[15] == 1'b0));
  a_r7_high_read_zero: assert property (@(posedge clk) disable iff (rst)
    (acc && !weIn && adrIn > ADDR_W'(ENABLE_ADDR)) |=> datOut == '0);

endmodule

bind txtbuf_bus_port txtbuf_bus_port_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TEXT_WORDS(TEXT_WORDS), .ENABLE_ADDR(ENABLE_ADDR)
) u_checker (
  .clk(clk), .rst(rst), .stbIn(stbIn), .weIn(weIn), .adrIn(adrIn), .datIn(datIn),
  .datOut(datOut), .ackOut(ackOut), .stallOut(stallOut), .dispEnable(dispEnable)
);

// File: tb/txtbuf_bus_port_test.sv
`timescale 1ns/1ps
module txtbuf_bus_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stbIn = 1'b0;
  logic        weIn = 1'b0;
  logic [10:0] adrIn = '0;
  logic [15:0] datIn = '0;
  logic [15:0] datOut;
  logic        ackOut;
  logic        stallOut;
  logic [10:0] dispAddr = '0;
  logic [15:0] dispData;
  logic        dispEnable;

  int checks = 0;
  int errors = 0;
  logic [15:0] rd;

  always #2.5 clk = ~clk;

  txtbuf_bus_port uut (
    .clk(clk), .rst(rst), .stbIn(stbIn), .weIn(weIn), .adrIn(adrIn), .datIn(datIn),
    .datOut(datOut), .ackOut(ackOut), .stallOut(stallOut),
    .dispAddr(dispAddr), .dispData(dispData), .dispEnable(dispEnable)
  );

  function automatic logic [7:0] expByte(input logic [7:0] b);
    return (b >= 8'h80) ? 8'h3F : b;
  endfunction
  function automatic logic [15:0] expWord(input logic [15:0] w);
    return {expByte(w[15:8]), expByte(w[7:0])};
  endfunction
  function automatic logic [15:0] pat(input int i);
    return 16'(i * 16'h0137 + 16'h002B);
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    stbIn = 1'b1; weIn = 1'b1; adrIn = a; datIn = d;
    @(negedge clk);
    stbIn = 1'b0; weIn = 1'b0;
    check("R2 write ack", 16'(ackOut), 16'd1);
  endtask

  task automatic busRead(input logic [10:0] a, output logic [15:0] d);
    @(negedge clk);
    stbIn = 1'b1; weIn = 1'b0; adrIn = a;
    @(negedge clk);
    stbIn = 1'b0;
    check("R2 read ack", 16'(ackOut), 16'd1);
    d = datOut;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 stall in reset", 16'(stallOut), 16'd1);
    check("R1 ack in reset", 16'(ackOut), 16'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 stall low", 16'(stallOut), 16'd0);
    check("R1 enable off", 16'(dispEnable), 16'd0);
    busRead(11'h500, rd);
    check("R1 reg read", rd, 16'h0000);
    @(negedge clk);
    check("R2 idle no ack", 16'(ackOut), 16'd0);

    // R4: every byte value, lanes on opposite sides of 0x80
    for (int b = 0; b < 256; b++) begin
      logic [15:0] w;
      w = {8'(b) ^ 8'h80, 8'(b)};
      busWrite(11'(b), w);
      busRead(11'(b), rd);
      check("R4 byte sanitise", rd, expWord(w));
    end

    // R3: full buffer pattern, then back-to-back reads (R2 pipelining)
    for (int i = 0; i < 1280; i++) busWrite(11'(i), pat(i));
    for (int i = 0; i <= 1280; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R2 pipelined ack", 16'(ackOut), 16'd1);
        check("R3 readback", datOut, expWord(pat(i - 1)));
      end
      if (i < 1280) begin
        stbIn = 1'b1; weIn = 1'b0; adrIn = 11'(i);
      end else stbIn = 1'b0;
    end

    // R6: display port scan
    for (int i = 0; i < 1280; i++) begin
      @(negedge clk);
      dispAddr = 11'(i);
      @(negedge clk);
      check("R6 display word", dispData, expWord(pat(i)));
    end
    busWrite(11'h000, 16'h4241);
    @(negedge clk); dispAddr = 11'h000;
    @(negedge clk);
    check("R6 low byte first char", 16'(dispData[7:0]), 16'h0041);
    check("R6 high byte second char", 16'(dispData[15:8]), 16'h0042);

    // R5: control register
    busWrite(11'h500, 16'h0001);
    check("R5 enable on", 16'(dispEnable), 16'd1);
    busRead(11'h500, rd);
    check("R5 read on", rd, 16'h0001);
    busWrite(11'h500, 16'h0000);
    check("R5 enable off", 16'(dispEnable), 16'd0);
    busRead(11'h500, rd);
    check("R5 read off", rd, 16'h0000);
    busWrite(11'h500, 16'h8000);
    check("R5 high bit on", 16'(dispEnable), 16'd1);

    // R7: unused space
    busWrite(11'h501, 16'h0000);
    busWrite(11'h7FF, 16'h0000);
    check("R7 enable kept", 16'(dispEnable), 16'd1);
    busWrite(11'h500, 16'h0000);
    busWrite(11'h6AB, 16'hFFFF);
    check("R7 enable stays off", 16'(dispEnable), 16'd0);
    busRead(11'h600, rd);
    check("R7 high read zero", rd, 16'h0000);
    busRead(11'h000, rd);
    check("R7 buffer untouched", rd, 16'h4241);
    busRead(11'h4FF, rd);
    check("R3 last word", rd, expWord(pat(1279)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule